// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Sequencer

This block drives the four gates of a full-bridge power stage. Each leg is a complementary pair: leg A has gates `gateA1`/`gateA2` and leg B has gates `gateB1`/`gateB2`. Output power is set by the phase offset between the two legs. The high-side/low-side duty of each leg stays at a square wave. The oscillator, the ramp comparator and the current comparator sit outside the block. Their decisions arrive as single-cycle or level inputs in the system clock domain.

A half-rate phase flag toggles on every oscillator tick. The flag chooses which leg answers the terminate event and which leg answers the next tick, so the two legs swap these roles every cycle. Every gate turn-on waits through a dead interval. The interval is counted in system clocks from a per-leg programmable value, which gives the switch node time to slew before the opposite device conducts. A global inhibit drops all four gates. When the inhibit is released, sequencing restarts from a fixed initial state.

Top module: `psfb_gate_seq`

## Requirements
- R1: While reset is held all four gates and `phaseFlag` are 0. In the first cycle after reset is released with `inhibit` low, the state is `gateA2`=1, `gateB1`=1, `gateA1`=0, `gateB2`=0, `phaseFlag`=0.
- R2: With `phaseFlag`=0, a `termStrobe` sampled at a clock edge drops `gateB1` after that edge. `gateB2` rises exactly max(`deadB`,1) cycles later.
- R3: A `limitTrip` ends the cycle exactly as `termStrobe` does: same leg, same timing.
- R4: With `phaseFlag`=0, an `oscTick` sampled at an edge drops `gateA2` after that edge. `gateA1` rises max(`deadA`,1) cycles later.
- R5: With `phaseFlag`=1 the roles swap. A terminate switches leg A from `gateA1` to `gateA2` with the leg A dead time. A tick switches leg B from `gateB2` to `gateB1` with the leg B dead time.
- R6: Only the first terminate event (`termStrobe` or `limitTrip`) after a tick takes effect. Later ones before the next tick leave all gates unchanged.
- R7: If no terminate event came since the previous tick, the tick switches both legs at once, each with its own dead time.
- R8: A dead-time value of 0 behaves as 1: the incoming gate rises one cycle after the outgoing gate falls.
- R9: The two gates of one leg are never high together. A switch request that reaches a leg during its dead interval reverses the leg's target and restarts the full dead interval.
- R10: An `inhibit` sampled at an edge forces all four gates low after that edge and holds `phaseFlag` at 0. After release, sequencing restarts in the R1 state.
- R11: `phaseFlag` toggles after each `oscTick` and changes at no other time, except when it is cleared by reset or inhibit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscTick | input | 1 | One-cycle oscillator pulse |
| termStrobe | input | 1 | Modulation comparator says end power delivery |
| limitTrip | input | 1 | Cycle-by-cycle current-limit trip |
| inhibit | input | 1 | Global gate disable |
| deadA | input | DW | Leg A dead interval in clocks (0 acts as 1) |
| deadB | input | DW | Leg B dead interval in clocks (0 acts as 1) |
| gateA1 | output | 1 | Leg A gate 1 |
| gateA2 | output | 1 | Leg A gate 2 |
| gateB1 | output | 1 | Leg B gate 1 |
| gateB2 | output | 1 | Leg B gate 2 |
| phaseFlag | output | 1 | Half-rate phase selector |

## Verification
The main sequence is exercised through a full two-phase cycle. The cycle ends once on the strobe and once on the current trip, with unequal dead times per leg, so a mix-up of leg and dead value shows up as a wrong rise cycle. A cycle with no terminate shows whether a tick switches both legs or leaves the bridge out of step. Repeated terminates within one cycle show that only the first one acts. A zero dead time checks the minimum interval. A switch request landing inside a long dead interval checks the reversal and the reload, and a monitor confirms that neither leg ever has both gates high.

// File: rtl/psfb_gate_seq_pkg.sv
package psfb_gate_seq_pkg;
  localparam int NUM_LEGS = 2;
  localparam int LEG_A = 0;
  localparam int LEG_B = 1;

  // strobes from the control to the leg datapaths
  typedef struct packed {
    logic                hold;   // keep legs in the initial state
    logic                outEn;  // allow gates to be driven
    logic [NUM_LEGS-1:0] flip;   // per-leg switch request
  } legCmd_t;
endpackage

// File: rtl/psfb_gate_seq_ctrl.sv
module psfb_gate_seq_ctrl
  import psfb_gate_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    oscTick,
  input  logic    termStrobe,
  input  logic    limitTrip,
  input  logic    inhibit,
  output legCmd_t cmd,
  output logic    phaseFlag
);
  logic idleQ, phaseQ, termDoneQ;
  logic active, termEv;

  assign active = !inhibit && !idleQ;
  assign termEv = (termStrobe || limitTrip) && !termDoneQ;

  always_comb begin
    cmd.hold  = inhibit || idleQ;
    cmd.outEn = !idleQ;
    // phase 0: terminate moves leg B, tick moves leg A; phase 1 swapped
    cmd.flip[LEG_A] = active && (oscTick ? (!phaseQ || !termDoneQ) : (phaseQ && termEv));
    cmd.flip[LEG_B] = active && (oscTick ? (phaseQ || !termDoneQ) : (!phaseQ && termEv));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleQ     <= 1'b1;
      phaseQ    <= 1'b0;
      termDoneQ <= 1'b0;
    end else if (!active) begin
      idleQ     <= inhibit;
      phaseQ    <= 1'b0;
      termDoneQ <= 1'b0;
    end else if (oscTick) begin
      phaseQ    <= ~phaseQ;
      termDoneQ <= 1'b0;
    end else if (termEv) begin
      termDoneQ <= 1'b1;
    end
  end

  assign phaseFlag = phaseQ;

  // R11: phase only moves after a tick or a forced clear
  p_phase_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ != $past(phaseQ)) |-> ($past(oscTick) || $past(inhibit) || $past(idleQ)));

  // R7: both legs switch together only on a tick with no terminate seen
  p_dual_flip_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.flip[LEG_A] && cmd.flip[LEG_B]) |-> (oscTick && !termDoneQ));

  // R6: after the first terminate, only a tick can produce a request
  p_single_term_r6: assert property (@(posedge clk) disable iff (!rstN)
    (termDoneQ && !oscTick) |-> (cmd.flip == '0));
endmodule

// File: rtl/psfb_gate_seq_leg.sv
module psfb_gate_seq_leg #(
  parameter int DW        = 16,
  parameter bit INIT_HIGH = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hold,
  input  logic          outEn,
  input  logic          flip,
  input  logic [DW-1:0] deadVal,
  output logic          gateHi,
  output logic          gateLo
);
  localparam logic [DW-1:0] MIN_DEAD = DW'(1);

  logic          sideQ;   // 1: gate 1 is the target, 0: gate 2
  logic [DW-1:0] cntQ;    // remaining dead clocks
  logic [DW-1:0] deadLoad;
  logic          settled;

  assign deadLoad = (deadVal == '0) ? MIN_DEAD : deadVal;
  assign settled  = (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sideQ <= INIT_HIGH;
      cntQ  <= '0;
    end else if (hold) begin
      sideQ <= INIT_HIGH;
      cntQ  <= '0;
    end else if (flip) begin
      sideQ <= ~sideQ;
      cntQ  <= deadLoad;
    end else if (!settled) begin
      cntQ  <= cntQ - MIN_DEAD;
    end
  end

  assign gateHi = outEn && settled && sideQ;
  assign gateLo = outEn && settled && !sideQ;

  // R9: a gate may only rise after its partner was low a full cycle
  p_gap_hi_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateHi) |-> !$past(gateLo));
  p_gap_lo_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateLo) |-> !$past(gateHi));

  // R8: a switch request always yields at least one dead cycle
  p_min_dead_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flip && !hold) |=> (!gateHi && !gateLo));
endmodule

// File: rtl/psfb_gate_seq.sv
module psfb_gate_seq
  import psfb_gate_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          oscTick,
  input  logic          termStrobe,
  input  logic          limitTrip,
  input  logic          inhibit,
  input  logic [DW-1:0] deadA,
  input  logic [DW-1:0] deadB,
  output logic          gateA1,
  output logic          gateA2,
  output logic          gateB1,
  output logic          gateB2,
  output logic          phaseFlag
);
  legCmd_t       cmd;
  logic [DW-1:0] deadArr [NUM_LEGS];
  logic          hiArr   [NUM_LEGS];
  logic          loArr   [NUM_LEGS];

  assign deadArr[LEG_A] = deadA;
  assign deadArr[LEG_B] = deadB;

  psfb_gate_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .oscTick   (oscTick),
    .termStrobe(termStrobe),
    .limitTrip (limitTrip),
    .inhibit   (inhibit),
    .cmd       (cmd),
    .phaseFlag (phaseFlag)
  );

  // leg A starts on gate 2, leg B on gate 1
  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_gate_seq_leg #(
      .DW       (DW),
      .INIT_HIGH(g == LEG_B)
    ) leg_i (
      .clk    (clk),
      .rstN   (rstN),
      .hold   (cmd.hold),
      .outEn  (cmd.outEn),
      .flip   (cmd.flip[g]),
      .deadVal(deadArr[g]),
      .gateHi (hiArr[g]),
      .gateLo (loArr[g])
    );
  end

  assign gateA1 = hiArr[LEG_A];
  assign gateA2 = loArr[LEG_A];
  assign gateB1 = hiArr[LEG_B];
  assign gateB2 = loArr[LEG_B];

  // R10: one sampled inhibit clears every gate by the next edge
  p_inhibit_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(inhibit) |-> !(gateA1 || gateA2 || gateB1 || gateB2));

  // R9: no shoot-through on either leg
  p_no_shoot_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(gateA1 && gateA2) && !(gateB1 && gateB2));
endmodule

// File: tb/psfb_gate_seq_tb_top.sv
`timescale 1ns/1ps
module psfb_gate_seq_tb_top;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic oscTick = 1'b0, termStrobe = 1'b0, limitTrip = 1'b0, inhibit = 1'b0;
  logic [DW-1:0] deadA = 16'd3, deadB = 16'd5;
  logic gateA1, gateA2, gateB1, gateB2, phaseFlag;

  int checks = 0;
  int bad = 0;
  int overlapSeen = 0;
  bit finished = 1'b0;

  psfb_gate_seq #(.DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .termStrobe(termStrobe),
    .limitTrip(limitTrip), .inhibit(inhibit), .deadA(deadA), .deadB(deadB),
    .gateA1(gateA1), .gateA2(gateA2), .gateB1(gateB1), .gateB2(gateB2),
    .phaseFlag(phaseFlag)
  );

  always @(negedge clk)
    if (rstN && ((gateA1 && gateA2) || (gateB1 && gateB2))) overlapSeen++;

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doTerm();
    @(negedge clk) termStrobe = 1'b1;
    @(negedge clk) termStrobe = 1'b0;
  endtask

  task automatic doTrip();
    @(negedge clk) limitTrip = 1'b1;
    @(negedge clk) limitTrip = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk) oscTick = 1'b1;
    @(negedge clk) oscTick = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk) inhibit = 1'b1;
    @(negedge clk);
    check("R10", "all gates low", gateA1 | gateA2 | gateB1 | gateB2, 1'b0);
    check("R10", "phase cleared", phaseFlag, 1'b0);
    inhibit = 1'b0;
    @(negedge clk);
    check("R10", "A2 restart", gateA2, 1'b1);
    check("R10", "B1 restart", gateB1, 1'b1);
  endtask

  task automatic t_reset();
    waitN(3);
    check("R1", "gates in reset", gateA1 | gateA2 | gateB1 | gateB2, 1'b0);
    check("R1", "phase in reset", phaseFlag, 1'b0);
    rstN = 1'b1;
    waitN(1);
    check("R1", "A2", gateA2, 1'b1);
    check("R1", "B1", gateB1, 1'b1);
    check("R1", "A1", gateA1, 1'b0);
    check("R1", "B2", gateB2, 1'b0);
  endtask

  task automatic t_basic();
    deadA = 16'd3; deadB = 16'd5;
    restart();
    doTerm();
    check("R2", "B1 off", gateB1, 1'b0);
    check("R2", "A2 held", gateA2, 1'b1);
    waitN(4); check("R2", "B2 still dead", gateB2, 1'b0);
    waitN(1); check("R2", "B2 on", gateB2, 1'b1);
    doTick();
    check("R4", "A2 off", gateA2, 1'b0);
    check("R11", "phase to 1", phaseFlag, 1'b1);
    check("R4", "B2 held", gateB2, 1'b1);
    waitN(2); check("R4", "A1 still dead", gateA1, 1'b0);
    waitN(1); check("R4", "A1 on", gateA1, 1'b1);
    doTrip();
    check("R3", "A1 off by trip", gateA1, 1'b0);
    check("R5", "B2 held", gateB2, 1'b1);
    waitN(2); check("R5", "A2 still dead", gateA2, 1'b0);
    waitN(1); check("R5", "A2 on", gateA2, 1'b1);
    doTick();
    check("R5", "B2 off", gateB2, 1'b0);
    check("R11", "phase to 0", phaseFlag, 1'b0);
    waitN(4); check("R5", "B1 still dead", gateB1, 1'b0);
    waitN(1); check("R5", "B1 on", gateB1, 1'b1);
  endtask

  task automatic t_single();
    deadA = 16'd3; deadB = 16'd5;
    restart();
    doTerm();
    waitN(5); check("R6", "B2 on", gateB2, 1'b1);
    doTerm();
    check("R6", "B2 kept", gateB2, 1'b1);
    doTrip();
    check("R6", "B2 kept after trip", gateB2, 1'b1);
    waitN(6);
    check("R6", "B1 stays off", gateB1, 1'b0);
    check("R6", "B2 stays on", gateB2, 1'b1);
    check("R6", "A2 stays on", gateA2, 1'b1);
    check("R11", "no tick, phase 0", phaseFlag, 1'b0);
  endtask

  task automatic t_forced();
    deadA = 16'd3; deadB = 16'd5;
    restart();
    doTick();
    check("R7", "A2 off", gateA2, 1'b0);
    check("R7", "B1 off", gateB1, 1'b0);
    check("R11", "phase 1", phaseFlag, 1'b1);
    waitN(2); check("R7", "A1 dead", gateA1, 1'b0);
    waitN(1);
    check("R7", "A1 on", gateA1, 1'b1);
    check("R7", "B2 dead", gateB2, 1'b0);
    waitN(2); check("R7", "B2 on", gateB2, 1'b1);
  endtask

  task automatic t_zero();
    deadA = 16'd0; deadB = 16'd0;
    restart();
    doTerm();
    check("R8", "B1 off", gateB1, 1'b0);
    check("R8", "B2 one dead cycle", gateB2, 1'b0);
    waitN(1); check("R8", "B2 on", gateB2, 1'b1);
    doTick();
    check("R8", "A1 one dead cycle", gateA1, 1'b0);
    waitN(1); check("R8", "A1 on", gateA1, 1'b1);
  endtask

  task automatic t_retrig();
    deadA = 16'd1; deadB = 16'd20;
    restart();
    doTerm();   // leg B heads to B2, long dead
    doTick();   // leg A switches, phase 1
    doTerm();   // leg A switches back
    doTick();   // leg B reversed inside its dead interval
    check("R9", "B1 low after reverse", gateB1, 1'b0);
    check("R9", "B2 low after reverse", gateB2, 1'b0);
    for (int i = 0; i < 19; i++) begin
      waitN(1);
      check("R9", "B2 never on", gateB2, 1'b0);
      check("R9", "B1 reload dead", gateB1, 1'b0);
    end
    waitN(1); check("R9", "B1 on after reload", gateB1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_single();
    t_forced();
    t_zero();
    t_retrig();
    checks++;
    if (overlapSeen != 0) begin
      bad++;
      $display("FAIL R9 leg overlap actual=%0d expected=0", overlapSeen);
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule